// File: doc/BRIEF.md
# Codec Command Response Tracker

This block sits between the command path of a serial audio link and the writer that stores codec responses in a ring. It accepts one command at a time. For each command it records which serial input lines must answer. A command addressed to one codec waits for that codec's line. A broadcast waits for every line marked present. The block accepts no further command until every awaited answer has arrived or a frame-based timeout has expired.

Responses arrive on up to two input lines, each carrying a 32-bit payload and a flag that marks the response as unsolicited. Every arriving response goes into one small merge buffer and comes out on a single valid/ready stream. Each output entry carries the number of the line it came from and its unsolicited flag. Unsolicited traffic shares this path with solicited traffic but never counts as the answer to a pending command.

Top module: `cmd_resp_tracker`

## Requirements
- R1: After reset, `cmd_ready` is 1, `out_valid` is 0, and both `timeout_err` bits and `overflow_err` are 0.
- R2: A non-broadcast command to codec `c` is accepted when `cmd_valid` is high while `cmd_ready` is 1. It makes `cmd_ready` 0 from the next cycle until the cycle after a response with flag 0 arrives on line `c`.
- R3: A broadcast (`cmd_bcast`=1) awaits one flag-0 response from each line whose bit is set in `present_mask`. `cmd_ready` returns only after all of them have arrived. With an empty mask, `cmd_ready` stays 1.
- R4: A response whose unsolicited flag is 1 comes out with `out_unsol`=1 and never satisfies a pending wait. A flag-0 response on a line that is not awaited comes out with `out_unsol`=0 and is also not counted.
- R5: Every response that is accepted into the buffer appears on the output with its payload on `out_data` and its line number on `out_codec`. If the buffer was empty, it appears in the cycle after it arrives.
- R6: When both lines deliver in the same cycle, the line 0 entry is output before the line 1 entry.
- R7: While `out_valid` is 1 and `out_ready` is 0, the output entry holds and does not change.
- R8: Each cycle with `frame_tick` high while a command is outstanding counts one frame. On the TIMEOUT_FRAMES-th frame, the `timeout_err` bit of every line still awaited is set and stays set. The command is dropped, and `cmd_ready` returns the next cycle.
- R9: The buffer holds BUF_DEPTH (default 4) entries, and a same-cycle pop frees a slot. An arrival that finds no free slot is dropped, line 1 before line 0, and sets `overflow_err`, which stays set.
- R10: A command presented while `cmd_ready` is 0 is ignored and does not change the set of awaited lines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_tick | input | 1 | One pulse per link frame |
| present_mask | input | NUM_LINES | Lines expected to answer a broadcast |
| cmd_valid | input | 1 | Command issued this cycle |
| cmd_bcast | input | 1 | Command is a broadcast |
| cmd_codec | input | IW | Target line of a non-broadcast command |
| cmd_ready | output | 1 | No command outstanding |
| rsp_valid | input | NUM_LINES | Response present per line |
| rsp_unsol | input | NUM_LINES | Unsolicited flag per line |
| rsp_data | input | NUM_LINES*DATA_W | Payload per line, line 0 in the low bits |
| out_valid | output | 1 | Output entry valid |
| out_ready | input | 1 | Consumer takes the entry |
| out_data | output | DATA_W | Response payload |
| out_codec | output | IW | Line the response came from |
| out_unsol | output | 1 | Response is unsolicited |
| timeout_err | output | NUM_LINES | Sticky no-response flag per line |
| overflow_err | output | 1 | Sticky buffer overflow flag |

## Verification
A pending set holding a bit it should not hold shows at the ports as `cmd_ready` staying low past the last awaited response. The error is caught in the next cycle, or it surfaces as a wrong `timeout_err` bit once the frame count runs out. A missing bit makes `cmd_ready` rise one cycle early. A buffer pointer or count that drifts shows on the first entry popped after it: a wrong payload, a wrong line tag or a spurious `out_valid`. A per-cycle reference model therefore flags it within a cycle. Losing the sticky error bits shows in the first cycle they drop.

// File: rtl/ctp_pkg.sv
package ctp_pkg;

   function automatic int idx_width(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

   function automatic bit is_pow2(input int n);
      return (n > 0) && ((n & (n - 1)) == 0);
   endfunction

endpackage

// File: rtl/ctp_pending.sv
module ctp_pending #(
   parameter int LINES          = 2,
   parameter int TIMEOUT_FRAMES = 64,
   parameter int IW             = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             frame_tick_i,
   input  logic [LINES-1:0] present_i,
   input  logic             cmd_valid_i,
   input  logic             cmd_bcast_i,
   input  logic [IW-1:0]    cmd_codec_i,
   input  logic [LINES-1:0] hit_i,
   output logic             cmd_ready_o,
   output logic [LINES-1:0] pend_o,
   output logic [LINES-1:0] timeout_err_o
);
   localparam int TW = $clog2(TIMEOUT_FRAMES + 1);

   logic [LINES-1:0] want_v, left_v, pend_d, pend_q, terr_q;
   logic [TW-1:0]    tmr_q;
   logic             idle, fire, expire;

   assign idle   = (pend_q == '0);
   assign fire   = idle && cmd_valid_i;
   assign expire = !idle && frame_tick_i && (tmr_q == TW'(TIMEOUT_FRAMES - 1));

   for (genvar l = 0; l < LINES; l++) begin : g_line
      assign want_v[l] = cmd_bcast_i ? present_i[l] : (cmd_codec_i == IW'(l));
      assign left_v[l] = pend_q[l] && !hit_i[l];
      assign pend_d[l] = fire ? want_v[l] : (expire ? 1'b0 : left_v[l]);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= '0;
         tmr_q  <= '0;
         terr_q <= '0;
      end else begin
         pend_q <= pend_d;
         if (fire) begin
            tmr_q <= '0;
         end else if (!idle && frame_tick_i) begin
            tmr_q <= expire ? '0 : tmr_q + 1'b1;
         end
         if (expire) begin
            terr_q <= terr_q | left_v;
         end
      end
   end

   assign cmd_ready_o   = idle;
   assign pend_o        = pend_q;
   assign timeout_err_o = terr_q;

   AST_PEND_NO_GROW: assert property (@(posedge clk) disable iff (!rst_n)
      !fire |=> ((pend_q & ~$past(pend_q)) == '0)); // R10
   AST_ERR_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_tick_i |=> $stable(terr_q)); // R8
   AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((terr_q & $past(terr_q)) == $past(terr_q))); // R8

endmodule

// File: rtl/ctp_rsp_fifo.sv
module ctp_rsp_fifo #(
   parameter int LINES = 2,
   parameter int DW    = 32,
   parameter int DEPTH = 4,
   parameter int IW    = 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [LINES-1:0]    push_v_i,
   input  logic [LINES*DW-1:0] push_data_i,
   input  logic [LINES-1:0]    push_unsol_i,
   input  logic                pop_ready_i,
   output logic                head_valid_o,
   output logic [DW-1:0]       head_data_o,
   output logic [IW-1:0]       head_idx_o,
   output logic                head_unsol_o,
   output logic                drop_o
);
   localparam int PW = $clog2(DEPTH);
   localparam int CW = $clog2(DEPTH + 1);

   logic [DW-1:0]    mem_d [DEPTH];
   logic [IW-1:0]    mem_i [DEPTH];
   logic             mem_u [DEPTH];
   logic [PW-1:0]    wr_q, rd_q;
   logic [CW-1:0]    cnt_q;
   logic             pop;
   logic [LINES-1:0] take;
   logic [PW-1:0]    slot [LINES];
   logic [CW-1:0]    n_take;

   always_comb begin
      int room;
      int used;
      pop    = (cnt_q != '0) && pop_ready_i;
      room   = DEPTH - int'(cnt_q) + (pop ? 1 : 0);
      used   = 0;
      take   = '0;
      drop_o = 1'b0;
      for (int l = 0; l < LINES; l++) begin
         slot[l] = wr_q + PW'(used);
         if (push_v_i[l]) begin
            if (used < room) begin
               take[l] = 1'b1;
               used    = used + 1;
            end else begin
               drop_o = 1'b1;
            end
         end
      end
      n_take = CW'(used);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_q  <= '0;
         rd_q  <= '0;
         cnt_q <= '0;
      end else begin
         wr_q  <= wr_q + PW'(n_take);
         rd_q  <= rd_q + PW'(pop);
         cnt_q <= cnt_q + n_take - CW'(pop);
      end
   end

   always_ff @(posedge clk) begin
      for (int l = 0; l < LINES; l++) begin
         if (take[l]) begin
            mem_d[slot[l]] <= push_data_i[l*DW +: DW];
            mem_i[slot[l]] <= IW'(l);
            mem_u[slot[l]] <= push_unsol_i[l];
         end
      end
   end

   assign head_valid_o = (cnt_q != '0);
   assign head_data_o  = mem_d[rd_q];
   assign head_idx_o   = mem_i[rd_q];
   assign head_unsol_o = mem_u[rd_q];

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      int'(cnt_q) <= DEPTH); // R9
   AST_HEAD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (head_valid_o && !pop_ready_i) |=> (head_valid_o && $stable(head_data_o)
         && $stable(head_idx_o) && $stable(head_unsol_o))); // R7

endmodule

// File: rtl/cmd_resp_tracker.sv
module cmd_resp_tracker #(
   parameter  int NUM_LINES      = 2,
   parameter  int DATA_W         = 32,
   parameter  int BUF_DEPTH      = 4,
   parameter  int TIMEOUT_FRAMES = 64,
   localparam int IW             = ctp_pkg::idx_width(NUM_LINES)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    frame_tick,
   input  logic [NUM_LINES-1:0]    present_mask,
   input  logic                    cmd_valid,
   input  logic                    cmd_bcast,
   input  logic [IW-1:0]           cmd_codec,
   output logic                    cmd_ready,
   input  logic [NUM_LINES-1:0]    rsp_valid,
   input  logic [NUM_LINES-1:0]    rsp_unsol,
   input  logic [NUM_LINES*DATA_W-1:0] rsp_data,
   output logic                    out_valid,
   input  logic                    out_ready,
   output logic [DATA_W-1:0]       out_data,
   output logic [IW-1:0]           out_codec,
   output logic                    out_unsol,
   output logic [NUM_LINES-1:0]    timeout_err,
   output logic                    overflow_err
);
   if (NUM_LINES < 1 || NUM_LINES > 2) begin : g_bad_lines
      $error("cmd_resp_tracker: NUM_LINES must be 1 or 2");
   end
   if (!ctp_pkg::is_pow2(BUF_DEPTH) || BUF_DEPTH < 2) begin : g_bad_depth
      $error("cmd_resp_tracker: BUF_DEPTH must be a power of two, at least 2");
   end
   if (TIMEOUT_FRAMES < 1 || DATA_W < 1) begin : g_bad_misc
      $error("cmd_resp_tracker: TIMEOUT_FRAMES and DATA_W must be positive");
   end

   logic [NUM_LINES-1:0] hit, pend;
   logic                 drop, ovf_q;

   assign hit = rsp_valid & ~rsp_unsol;

   ctp_pending #(
      .LINES(NUM_LINES), .TIMEOUT_FRAMES(TIMEOUT_FRAMES), .IW(IW)
   ) pend_i (
      .clk(clk), .rst_n(rst_n), .frame_tick_i(frame_tick),
      .present_i(present_mask), .cmd_valid_i(cmd_valid),
      .cmd_bcast_i(cmd_bcast), .cmd_codec_i(cmd_codec), .hit_i(hit),
      .cmd_ready_o(cmd_ready), .pend_o(pend), .timeout_err_o(timeout_err)
   );

   ctp_rsp_fifo #(
      .LINES(NUM_LINES), .DW(DATA_W), .DEPTH(BUF_DEPTH), .IW(IW)
   ) fifo_i (
      .clk(clk), .rst_n(rst_n), .push_v_i(rsp_valid), .push_data_i(rsp_data),
      .push_unsol_i(rsp_unsol), .pop_ready_i(out_ready),
      .head_valid_o(out_valid), .head_data_o(out_data),
      .head_idx_o(out_codec), .head_unsol_o(out_unsol), .drop_o(drop)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ovf_q <= 1'b0;
      else if (drop) ovf_q <= 1'b1;
   end
   assign overflow_err = ovf_q;

   for (genvar l = 0; l < NUM_LINES; l++) begin : g_chk
      AST_UNSOL_NOT_COUNTED: assert property (@(posedge clk) disable iff (!rst_n)
         (rsp_valid[l] && rsp_unsol[l] && pend[l] && !frame_tick) |=> pend[l]); // R4
   end
   AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      $past(overflow_err) |-> overflow_err); // R9

endmodule

// File: tb/cmd_resp_tracker_tb_top.sv
module cmd_resp_tracker_tb_top;
   localparam int DW = 32, DEPTH = 4, TO = 64;

   logic clk = 1'b0, rst_n = 1'b0;
   always #5 clk = ~clk;

   logic frame_tick = 0, cmd_valid = 0, cmd_bcast = 0, out_ready = 1;
   logic [1:0] present_mask = 2'b11, rsp_valid = '0, rsp_unsol = '0;
   logic [0:0] cmd_codec = '0;
   logic [2*DW-1:0] rsp_data = '0;
   logic cmd_ready, out_valid, out_unsol, overflow_err;
   logic [DW-1:0] out_data;
   logic [0:0] out_codec;
   logic [1:0] timeout_err;

   cmd_resp_tracker dut_i (
      .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick), .present_mask(present_mask),
      .cmd_valid(cmd_valid), .cmd_bcast(cmd_bcast), .cmd_codec(cmd_codec),
      .cmd_ready(cmd_ready), .rsp_valid(rsp_valid), .rsp_unsol(rsp_unsol),
      .rsp_data(rsp_data), .out_valid(out_valid), .out_ready(out_ready),
      .out_data(out_data), .out_codec(out_codec), .out_unsol(out_unsol),
      .timeout_err(timeout_err), .overflow_err(overflow_err)
   );

   int checks = 0, errors = 0;

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   typedef struct { logic [DW-1:0] d; int idx; bit u; } ent_t;
   ent_t mq[$];
   logic [1:0] m_pend = '0, m_terr = '0;
   int m_timer = 0;
   bit m_ovf = 0;

   always @(posedge clk) begin
      if (!rst_n) begin
         mq.delete(); m_pend = '0; m_terr = '0; m_timer = 0; m_ovf = 0;
      end else begin
         int free;
         bit pop;
         logic [1:0] np;
         pop  = (mq.size() > 0) && out_ready;
         free = DEPTH - mq.size() + (pop ? 1 : 0);
         if (pop) void'(mq.pop_front());
         for (int l = 0; l < 2; l++) begin
            if (rsp_valid[l]) begin
               if (free > 0) begin
                  mq.push_back('{rsp_data[l*DW +: DW], l, rsp_unsol[l]});
                  free--;
               end else m_ovf = 1;
            end
         end
         if (m_pend == 0) begin
            if (cmd_valid) begin
               m_pend  = cmd_bcast ? present_mask : (2'b01 << cmd_codec);
               m_timer = 0;
            end
         end else begin
            np = m_pend & ~(rsp_valid & ~rsp_unsol);
            if (frame_tick) begin
               if (m_timer == TO - 1) begin
                  m_terr |= np; np = '0; m_timer = 0;
               end else m_timer++;
            end
            m_pend = np;
         end
      end
   end

   always @(negedge clk) begin
      if (rst_n) begin
         chk(cmd_ready === (m_pend == 0), "R2 cmd_ready", cmd_ready, m_pend == 0);
         chk(out_valid === (mq.size() > 0), "R5 out_valid", out_valid, mq.size() > 0);
         if (mq.size() > 0) begin
            chk(out_data === mq[0].d, "R5 out_data", out_data, mq[0].d);
            chk(out_codec === 1'(mq[0].idx), "R5 out_codec", out_codec, mq[0].idx);
            chk(out_unsol === mq[0].u, "R4 out_unsol", out_unsol, mq[0].u);
         end
         chk(timeout_err === m_terr, "R8 timeout_err", timeout_err, m_terr);
         chk(overflow_err === m_ovf, "R9 overflow_err", overflow_err, m_ovf);
      end
   end

   task automatic step(); @(negedge clk); endtask

   task automatic issue(input bit bc, input bit codec);
      cmd_valid = 1; cmd_bcast = bc; cmd_codec = codec;
      step();
      cmd_valid = 0; cmd_bcast = 0;
   endtask

   task automatic respond(input logic [1:0] v, input logic [1:0] u, input logic [DW-1:0] d0,
                          input logic [DW-1:0] d1);
      rsp_valid = v; rsp_unsol = u; rsp_data = {d1, d0};
      step();
      rsp_valid = '0; rsp_unsol = '0;
   endtask

   task automatic summary();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      #2000000;
      chk(0, "watchdog", 0, 1);
      summary();
   end

   initial begin
      repeat (3) step();
      // R1 reset state
      chk(cmd_ready === 1'b1, "R1 cmd_ready", cmd_ready, 1);
      chk(out_valid === 1'b0, "R1 out_valid", out_valid, 0);
      chk(timeout_err === 2'b00 && overflow_err === 1'b0, "R1 errors",
          {timeout_err, overflow_err}, 0);
      rst_n = 1;
      step();

      // R2 single command to codec 1, R4 unawaited line 0 not counted
      issue(0, 1);
      chk(cmd_ready === 1'b0, "R2 busy after accept", cmd_ready, 0);
      respond(2'b01, 2'b00, 32'h1111_0000, 0);
      chk(cmd_ready === 1'b0, "R4 unawaited line not counted", cmd_ready, 0);
      respond(2'b10, 2'b00, 0, 32'hA5A5_0001);
      chk(cmd_ready === 1'b1, "R2 ready after response", cmd_ready, 1);
      chk(out_codec === 1'b1 && out_data === 32'hA5A5_0001, "R5 tag and payload",
          {out_codec, out_data}, {1'b1, 32'hA5A5_0001});
      step();

      // R10 command while busy ignored
      issue(0, 1);
      issue(0, 0);
      respond(2'b10, 2'b00, 0, 32'h2222_0001);
      chk(cmd_ready === 1'b1, "R10 busy command ignored", cmd_ready, 1);
      step();

      // R3 broadcast to two present lines
      issue(1, 0);
      respond(2'b01, 2'b00, 32'h3333_0000, 0);
      chk(cmd_ready === 1'b0, "R3 still awaiting line 1", cmd_ready, 0);
      respond(2'b10, 2'b00, 0, 32'h3333_0001);
      chk(cmd_ready === 1'b1, "R3 all answered", cmd_ready, 1);
      step();

      // R6 same-cycle order, R7 hold under backpressure
      issue(1, 0);
      out_ready = 0;
      respond(2'b11, 2'b00, 32'h4444_0000, 32'h4444_0001);
      chk(out_codec === 1'b0, "R6 line 0 first", out_codec, 0);
      step();
      chk(out_valid === 1'b1 && out_data === 32'h4444_0000, "R7 head held", out_data, 32'h4444_0000);
      out_ready = 1;
      step();
      chk(out_codec === 1'b1 && out_data === 32'h4444_0001, "R6 line 1 second",
          out_data, 32'h4444_0001);
      step();

      // R3 partial and empty masks
      present_mask = 2'b01;
      issue(1, 0);
      respond(2'b01, 2'b00, 32'h5555_0000, 0);
      chk(cmd_ready === 1'b1, "R3 single present line", cmd_ready, 1);
      present_mask = 2'b00;
      issue(1, 0);
      chk(cmd_ready === 1'b1, "R3 empty mask", cmd_ready, 1);
      present_mask = 2'b11;
      step();

      // R4 unsolicited not counted
      issue(0, 0);
      respond(2'b01, 2'b01, 32'h6666_0000, 0);
      chk(cmd_ready === 1'b0, "R4 unsolicited not counted", cmd_ready, 0);
      chk(out_unsol === 1'b1, "R4 unsolicited marked", out_unsol, 1);
      respond(2'b01, 2'b00, 32'h6666_0001, 0);
      chk(cmd_ready === 1'b1, "R4 solicited completes", cmd_ready, 1);
      step();

      // R8 timeout
      issue(0, 1);
      for (int i = 0; i < TO - 1; i++) begin
         frame_tick = 1; step(); frame_tick = 0; step();
      end
      chk(cmd_ready === 1'b0 && timeout_err === 2'b00, "R8 before last frame",
          {cmd_ready, timeout_err}, 0);
      frame_tick = 1; step(); frame_tick = 0;
      chk(timeout_err === 2'b10, "R8 error on line 1", timeout_err, 2'b10);
      chk(cmd_ready === 1'b1, "R8 command dropped", cmd_ready, 1);
      step();

      // R9 overflow
      out_ready = 0;
      respond(2'b11, 2'b00, 32'h7777_0000, 32'h7777_0001);
      respond(2'b11, 2'b10, 32'h7777_0002, 32'h7777_0003);
      chk(overflow_err === 1'b0, "R9 full but no loss", overflow_err, 0);
      respond(2'b11, 2'b00, 32'h7777_0004, 32'h7777_0005);
      chk(overflow_err === 1'b1, "R9 overflow flagged", overflow_err, 1);
      out_ready = 1;
      respond(2'b10, 2'b00, 0, 32'h7777_0006);
      repeat (6) step();
      chk(out_valid === 1'b0 && overflow_err === 1'b1, "R9 drained, sticky",
          {out_valid, overflow_err}, 1);

      summary();
   end
endmodule